// File: doc/BRIEF.md
# Push-Pull Gate Sequencer with Fault Handling

This block produces the two gate-drive signals for a centre-tapped push-pull transformer stage. It runs on the oscillator clock and divides it by two. The resulting two phases drive gate A and gate B in antiphase. Each gate is high for one clock of every two, so each has a 50% duty cycle.

The block also sequences the fault responses. An overcurrent report from either switch does not stop switching. Instead, both gates keep alternating and the current limit is switched to its reduced level for a fixed retry window. At the end of the window the overcurrent flag is checked again. An overtemperature report opens both switches and preempts any retry window. Disable and undervoltage both hold the gates off and return the sequencer to its idle state.

The comparators, the relaxation oscillator and the power switches sit outside this block. The thermal hysteresis is applied upstream.

Top module: `pp_gate_ctrl`

## Requirements
- R1: While switching, gate_a and gate_b alternate on every clock, so each gate is high for exactly one clock out of two.
- R2: When oc_flag is sampled high in normal switching, the block enters current-limit mode on the next clock edge. In current-limit mode both gates keep alternating.
- R3: ilim_low and stat_ilim are high exactly while the block is in current-limit mode. They change in the same cycle as the state.
- R4: A current-limit window lasts WIN_CYCLES clocks (default 4096). If oc_flag is low on the last clock of the window, normal mode resumes.
- R5: If oc_flag is high on the last clock of a window, a fresh window of the same length starts and current-limit mode continues without a break.
- R6: While enabled and without undervoltage, an asserted ot_flag moves the block to thermal shutdown on the next edge, from any state. In thermal shutdown both gates are low, stat_therm is high and stat_ilim is low.
- R7: When ot_flag clears, the block returns to normal mode, never to current-limit mode, and the retry count starts again from zero.
- R8: When en is low, both gates and both status flags are low from the next edge on, and the fault state is cleared.
- R9: gate_a and gate_b are never high in the same cycle.
- R10: On leaving any off state (reset, disable, undervoltage, thermal shutdown), gate_a is the first gate driven high.
- R11: An asserted uv_flag acts exactly like a low en.
- R12: rst_n clears the block asynchronously. After rst_n rises, the block stays idle for two clock edges, and switching starts at the third edge if en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Switching enable, active high |
| oc_flag | input | 1 | Overcurrent comparator output, synchronous to clk |
| ot_flag | input | 1 | Overtemperature flag, hysteresis applied upstream |
| uv_flag | input | 1 | Supply undervoltage flag |
| gate_a | output | 1 | Gate drive for switch A |
| gate_b | output | 1 | Gate drive for switch B |
| ilim_low | output | 1 | Selects the reduced current limit |
| stat_ilim | output | 1 | Current-limit mode status |
| stat_therm | output | 1 | Thermal shutdown status |

## Verification
A wrong phase register shows up within one clock, either as a gate that fails to alternate or as gate B leading after a restart. A wrong fault state shows up on the status flags in the very cycle it is entered. A retry counter that is off by even one count changes the cycle in which stat_ilim falls. The bench's reference model therefore exposes it at the end of the first window, about four thousand clocks after the trip. A counter that is not cleared on leaving thermal shutdown shows up only in the next window, so the bench runs a window after the thermal exit.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_ILIM = 2'd2,
    ST_HOT  = 2'd3
  } pp_state_e;
endpackage

// File: rtl/pp_retry_timer.sv
module pp_retry_timer #(
  parameter int WIN_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic win_done
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign win_done = count_en && (cnt_q == LAST);

  always_comb begin
    if (count_en && !win_done) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> cnt_q == '0);
endmodule

// File: rtl/pp_fault_fsm.sv
module pp_fault_fsm
  import pp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      oc_i,
  input  logic      ot_i,
  input  logic      uv_i,
  input  logic      win_done_i,
  output pp_state_e st_o
);
  pp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en_i || uv_i) begin
      st_d = ST_OFF;
    end else if (ot_i) begin
      st_d = ST_HOT;
    end else begin
      unique case (st_q)
        ST_OFF:  st_d = ST_RUN;
        ST_HOT:  st_d = ST_RUN;
        ST_RUN:  st_d = oc_i ? ST_ILIM : ST_RUN;
        ST_ILIM: st_d = (win_done_i && !oc_i) ? ST_RUN : ST_ILIM;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  // R7
  hot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_HOT |=> st_q != ST_ILIM);
endmodule

// File: rtl/pp_phase_gen.sv
module pp_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic gate_a_o,
  output logic gate_b_o
);
  logic ph_q, ph_d;

  always_comb begin
    if (run_i) ph_d = ~ph_q;
    else       ph_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign gate_a_o = run_i && !ph_q;
  assign gate_b_o = run_i &&  ph_q;

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a_o && gate_b_o));

  // R10
  a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> gate_a_o);

  // R1
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_a_o |=> (gate_b_o || !run_i));
endmodule

// File: rtl/pp_gate_ctrl.sv
module pp_gate_ctrl
  import pp_pkg::*;
#(
  parameter int WIN_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic oc_flag,
  input  logic ot_flag,
  input  logic uv_flag,
  output logic gate_a,
  output logic gate_b,
  output logic ilim_low,
  output logic stat_ilim,
  output logic stat_therm
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       win_done;
  logic       run;
  pp_state_e  st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pp_fault_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (en),
    .oc_i       (oc_flag),
    .ot_i       (ot_flag),
    .uv_i       (uv_flag),
    .win_done_i (win_done),
    .st_o       (st)
  );

  pp_retry_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .count_en (st == ST_ILIM),
    .win_done (win_done)
  );

  assign run = (st == ST_RUN) || (st == ST_ILIM);

  pp_phase_gen u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_i    (run),
    .gate_a_o (gate_a),
    .gate_b_o (gate_b)
  );

  assign ilim_low   = (st == ST_ILIM);
  assign stat_ilim  = (st == ST_ILIM);
  assign stat_therm = (st == ST_HOT);

  // R8
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> !gate_a && !gate_b && !stat_ilim && !stat_therm);

  // R11
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    uv_flag |=> !gate_a && !gate_b && !stat_ilim && !stat_therm);

  // R6
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ot_flag && en && !uv_flag) |=> !gate_a && !gate_b && stat_therm);

  // R2
  oc_trip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_flag && en && !uv_flag && !ot_flag && (gate_a || gate_b)) |=> ilim_low);
endmodule

// File: tb/pp_gate_ctrl_test.sv
module pp_gate_ctrl_test;
  localparam int WIN = 4096;

  logic clk = 1'b0;
  logic rst_n, en, oc_flag, ot_flag, uv_flag;
  logic gate_a, gate_b, ilim_low, stat_ilim, stat_therm;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pp_gate_ctrl #(.WIN_CYCLES(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .uv_flag(uv_flag), .gate_a(gate_a), .gate_b(gate_b), .ilim_low(ilim_low),
    .stat_ilim(stat_ilim), .stat_therm(stat_therm)
  );

  // Behavioural reference: mode 0 idle, 1 normal, 2 limiting, 3 hot
  int  m_rs, m_mode, m_cnt;
  bit  m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_mode = 0; m_cnt = 0; m_ph = 0;
    end else if (m_rs < 2) begin
      m_rs = m_rs + 1;
    end else begin
      bit act, last;
      int nm;
      act  = (m_mode == 1) || (m_mode == 2);
      last = (m_mode == 2) && (m_cnt == WIN - 1);
      if (!en || uv_flag) nm = 0;
      else if (ot_flag) nm = 3;
      else if (m_mode == 0 || m_mode == 3) nm = 1;
      else if (m_mode == 1) nm = oc_flag ? 2 : 1;
      else nm = (last && !oc_flag) ? 1 : 2;
      m_cnt  = (m_mode == 2 && !last) ? m_cnt + 1 : 0;
      m_ph   = act ? !m_ph : 1'b0;
      m_mode = nm;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit act;
      act = (m_mode == 1) || (m_mode == 2);
      chk("R1", "gate_a", gate_a, act && !m_ph);
      chk("R1", "gate_b", gate_b, act && m_ph);
      chk("R3", "ilim_low", ilim_low, m_mode == 2);
      chk("R3", "stat_ilim", stat_ilim, m_mode == 2);
      chk("R6", "stat_therm", stat_therm, m_mode == 3);
      chk("R9", "overlap", gate_a && gate_b, 0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len;
    rst_n = 1'b0; en = 1'b0; oc_flag = 1'b0; ot_flag = 1'b0; uv_flag = 1'b0;
    step(3);
    chk("R12", "gates in reset", gate_a | gate_b, 0);
    chk("R12", "status in reset", stat_ilim | stat_therm | ilim_low, 0);
    rst_n = 1'b1; en = 1'b1;
    step(2);
    chk("R12", "idle after two edges", gate_a | gate_b, 0);
    step(1);
    chk("R10", "A first after reset", gate_a, 1);
    step(1);
    chk("R1", "B follows A", gate_b, 1);
    step(10);

    // R2 / R4: single-cycle trip, measure window length
    oc_flag = 1'b1;
    step(1);
    oc_flag = 1'b0;
    chk("R2", "trip enters limit", stat_ilim, 1);
    chk("R3", "reduced limit select", ilim_low, 1);
    len = 0;
    while (stat_ilim && len < WIN + 10) begin
      len++;
      step(1);
    end
    chk("R4", "window length", len, WIN);
    chk("R4", "normal after window", gate_a | gate_b, 1);

    // R5: held overcurrent retriggers the window
    oc_flag = 1'b1;
    step(WIN + 20);
    chk("R5", "still limiting after window", stat_ilim, 1);

    // R6: overtemperature preempts the window
    ot_flag = 1'b1;
    step(1);
    chk("R6", "thermal state", stat_therm, 1);
    chk("R6", "gates open", gate_a | gate_b, 0);
    chk("R6", "limit status cleared", stat_ilim, 0);
    step(5);
    // R7 / R10: exit to normal even with overcurrent present
    ot_flag = 1'b0;
    step(1);
    chk("R7", "exit to normal", stat_ilim, 0);
    chk("R10", "A first after thermal", gate_a, 1);
    step(1);
    chk("R7", "limit after normal", stat_ilim, 1);
    oc_flag = 1'b0;
    len = 0;
    while (stat_ilim && len < WIN + 10) begin
      len++;
      step(1);
    end
    chk("R7", "window after thermal exit", len, WIN);

    // R8: disable during limiting
    oc_flag = 1'b1;
    step(5);
    en = 1'b0; oc_flag = 1'b0;
    step(1);
    chk("R8", "disabled gates", gate_a | gate_b, 0);
    chk("R8", "disabled status", stat_ilim | stat_therm, 0);
    step(4);
    en = 1'b1;
    step(1);
    chk("R10", "A first after enable", gate_a, 1);
    chk("R8", "fault state cleared", stat_ilim, 0);

    // R11: undervoltage during thermal shutdown
    ot_flag = 1'b1;
    step(3);
    uv_flag = 1'b1;
    step(1);
    chk("R11", "uv gates", gate_a | gate_b, 0);
    chk("R11", "uv clears thermal", stat_therm, 0);
    ot_flag = 1'b0;
    step(3);
    uv_flag = 1'b0;
    step(1);
    chk("R11", "A first after uv", gate_a, 1);
    step(1);
    chk("R1", "B after uv restart", gate_b, 1);
    step(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule